// File: doc/BRIEF.md
# Synthesizer Serial Programming Register File

This block is the serial programming front end of a fractional-N frequency synthesizer. A three-wire port (serial clock, serial data, latch enable) loads a 24-bit word, most significant bit first. On each rising edge of latch enable, the word is copied into one of four holding registers. The two lowest bits of the word choose the register: the integer/fraction divider word, the reference divider word, the control word or the noise/spur word.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and edges are detected in the system clock domain. The block presents the decoded fields to the synthesizer core: the 9-bit integer, the 12-bit fraction, the 4-bit reference count and the two 22-bit payload words. The modulus is double buffered. A reference divider write only places a new modulus in a pending buffer. The active modulus takes that value at the next integer/fraction divider write, so that the fraction and the modulus change together.

Top module: `synth_prog_regfile`

## Requirements
- R1: While `rst` is high and after it falls, every field output, `mod_pending` and `mod_active` are zero and `upd_strobe` is low, until the first transfer.
- R2: Serial bits are taken on each rising edge of `ser_clk`, most significant bit first. The word transferred is the last 24 bits shifted in.
- R3: Word bits [1:0] select exactly one destination: 0 = divider word, 1 = reference word, 2 = control word, 3 = noise word. A transfer leaves every other holding register unchanged.
- R4: A divider word sets `n_frac` from bits [13:2] and `n_int` from bits [22:14]. Bit 23 is ignored.
- R5: A reference word sets `mod_pending` from bits [13:2] and `r_count` from bits [17:14]. Bits [23:18] are ignored.
- R6: A reference word write never changes `mod_active`.
- R7: A divider word write copies `mod_pending` into `mod_active`. When no reference write has occurred since the last commit, the active modulus stays the same.
- R8: A control or noise word write stores bits [23:2] in `ctrl_word` or `noise_word`.
- R9: Each transfer raises `upd_strobe` for exactly one system clock cycle, with `upd_idx` equal to the destination code of R3.
- R10: Shifting while `ser_le` is high is accepted and causes no transfer. Only a rising edge of `ser_le` transfers, and it uses the shift register contents present at that edge.
- R11: Shifting without a rising edge of `ser_le` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Latch enable; its rising edge transfers the word (asynchronous) |
| n_int | output | 9 | Integer divider value |
| n_frac | output | 12 | Fractional value |
| r_count | output | 4 | Reference counter value |
| mod_pending | output | 12 | Modulus captured but not yet committed |
| mod_active | output | 12 | Modulus in effect |
| ctrl_word | output | 22 | Control word payload |
| noise_word | output | 22 | Noise/spur word payload |
| upd_strobe | output | 1 | One-cycle pulse for each register update |
| upd_idx | output | 2 | Destination code of the update |

## Verification
The assertions check on every cycle the following:
- A holding register or modulus changes only in the cycle of a strobe that names its own destination.
- The active modulus changes only on a divider write, and then takes the previous pending value.
- The strobe never lasts two cycles.

The following can only be shown by the bench's scenarios, which sweep computed word patterns across all four destinations:
- The bit order and field placement.
- That bits beyond 24 shift out.
- That shifting while latch enable is held high does nothing until the next rising edge.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int WORD_W   = 24;
    localparam int SEL_W    = 2;
    localparam int PAYLD_W  = WORD_W - SEL_W;

    localparam int NINT_W   = 9;
    localparam int FRAC_W   = 12;
    localparam int RCNT_W   = 4;
    localparam int MOD_W    = 12;

    localparam int FRAC_LSB = SEL_W;
    localparam int NINT_LSB = FRAC_LSB + FRAC_W;
    localparam int MOD_LSB  = SEL_W;
    localparam int RCNT_LSB = MOD_LSB + MOD_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_NDIV  = 2'd0,
        SEL_RDIV  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NOISE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NINT_W-1:0] nint;
        logic [FRAC_W-1:0] frac;
    } ndiv_t;

    typedef struct packed {
        logic [RCNT_W-1:0] rcnt;
        logic [MOD_W-1:0]  modv;
    } rdiv_t;

    function automatic reg_sel_e sel_of(input logic [SEL_W-1:0] bits);
        return reg_sel_e'(bits);
    endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic [WORD_W-1:0] word
);
    logic sclk_d;
    logic shift_en;

    assign shift_en = sclk_s & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            word   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (shift_en) word <= {word[WORD_W-2:0], sdat_s};
        end
    end
endmodule

// File: rtl/sp_modbuf.sv
module sp_modbuf
    import synth_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_pend,
    input  logic [MOD_W-1:0] pend_in,
    input  logic             commit,
    output logic [MOD_W-1:0] pending,
    output logic [MOD_W-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (load_pend) pending <= pend_in;
            if (commit)    active  <= pending;
        end
    end
endmodule

// File: rtl/sp_regbank.sv
module sp_regbank
    import synth_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               le_s,
    input  logic [WORD_W-1:0]  word,
    output ndiv_t              ndiv,
    output logic [RCNT_W-1:0]  rcnt,
    output logic [PAYLD_W-1:0] ctrl,
    output logic [PAYLD_W-1:0] noise,
    output logic               wr_rdiv,
    output logic               wr_ndiv,
    output logic [MOD_W-1:0]   mod_field,
    output logic               strobe,
    output logic [SEL_W-1:0]   idx
);
    logic     le_d;
    logic     xfer;
    reg_sel_e sel;
    ndiv_t    n_next;
    rdiv_t    r_next;

    assign xfer    = le_s & ~le_d;
    assign sel     = sel_of(word[SEL_W-1:0]);
    assign n_next  = '{nint: word[NINT_LSB +: NINT_W], frac: word[FRAC_LSB +: FRAC_W]};
    assign r_next  = '{rcnt: word[RCNT_LSB +: RCNT_W], modv: word[MOD_LSB +: MOD_W]};
    assign wr_ndiv = xfer && (sel == SEL_NDIV);
    assign wr_rdiv = xfer && (sel == SEL_RDIV);
    assign mod_field = r_next.modv;

    always_ff @(posedge clk) begin
        if (rst) begin
            le_d   <= 1'b0;
            ndiv   <= '0;
            rcnt   <= '0;
            ctrl   <= '0;
            noise  <= '0;
            strobe <= 1'b0;
            idx    <= '0;
        end else begin
            le_d   <= le_s;
            strobe <= xfer;
            if (xfer) begin
                idx <= word[SEL_W-1:0];
                unique case (sel)
                    SEL_NDIV:  ndiv  <= n_next;
                    SEL_RDIV:  rcnt  <= r_next.rcnt;
                    SEL_CTRL:  ctrl  <= word[WORD_W-1:SEL_W];
                    SEL_NOISE: noise <= word[WORD_W-1:SEL_W];
                endcase
            end
        end
    end
endmodule

// File: rtl/synth_prog_regfile.sv
module synth_prog_regfile
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_le,
    output logic [NINT_W-1:0]  n_int,
    output logic [FRAC_W-1:0]  n_frac,
    output logic [RCNT_W-1:0]  r_count,
    output logic [MOD_W-1:0]   mod_pending,
    output logic [MOD_W-1:0]   mod_active,
    output logic [PAYLD_W-1:0] ctrl_word,
    output logic [PAYLD_W-1:0] noise_word,
    output logic               upd_strobe,
    output logic [SEL_W-1:0]   upd_idx
);
    localparam int NSIG = 3;

    logic [NSIG-1:0]   pins_s;
    logic [WORD_W-1:0] sh_word;
    ndiv_t             ndiv;
    logic              wr_rdiv;
    logic              wr_ndiv;
    logic [MOD_W-1:0]  mod_field;

    sp_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_le, ser_clk, ser_data}),
        .q   (pins_s)
    );

    sp_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s[1]),
        .sdat_s (pins_s[0]),
        .word   (sh_word)
    );

    sp_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .le_s      (pins_s[2]),
        .word      (sh_word),
        .ndiv      (ndiv),
        .rcnt      (r_count),
        .ctrl      (ctrl_word),
        .noise     (noise_word),
        .wr_rdiv   (wr_rdiv),
        .wr_ndiv   (wr_ndiv),
        .mod_field (mod_field),
        .strobe    (upd_strobe),
        .idx       (upd_idx)
    );

    sp_modbuf u_mod (
        .clk       (clk),
        .rst       (rst),
        .load_pend (wr_rdiv),
        .pend_in   (mod_field),
        .commit    (wr_ndiv),
        .pending   (mod_pending),
        .active    (mod_active)
    );

    assign n_int  = ndiv.nint;
    assign n_frac = ndiv.frac;
endmodule

// File: rtl/sp_regfile_checker.sv
module sp_regfile_checker
    import synth_prog_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NINT_W-1:0]  n_int,
    input logic [FRAC_W-1:0]  n_frac,
    input logic [RCNT_W-1:0]  r_count,
    input logic [MOD_W-1:0]   mod_pending,
    input logic [MOD_W-1:0]   mod_active,
    input logic [PAYLD_W-1:0] ctrl_word,
    input logic [PAYLD_W-1:0] noise_word,
    input logic               upd_strobe,
    input logic [SEL_W-1:0]   upd_idx
);
    // R9: a strobe never lasts two cycles
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> !upd_strobe);

    // R3 / R4: divider fields move only on a divider strobe
    a_r3_ndiv_only: assert property (@(posedge clk) disable iff (rst)
        (!$stable(n_int) || !$stable(n_frac)) |-> (upd_strobe && upd_idx == 2'd0));

    // R3 / R5: reference fields move only on a reference strobe
    a_r5_rdiv_only: assert property (@(posedge clk) disable iff (rst)
        (!$stable(r_count) || !$stable(mod_pending)) |-> (upd_strobe && upd_idx == 2'd1));

    // R8: payload words move only on their own strobe
    a_r8_ctrl_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> (upd_strobe && upd_idx == 2'd2));
    a_r8_noise_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(noise_word) |-> (upd_strobe && upd_idx == 2'd3));

    // R6: the active modulus moves only on a divider strobe
    a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(mod_active) |-> (upd_strobe && upd_idx == 2'd0));

    // R7: a divider strobe commits the previous pending value
    a_r7_commit: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && upd_idx == 2'd0) |-> (mod_active == $past(mod_pending)));

    // R1: outputs are clear while reset is applied
    always @(posedge clk) begin
        if (rst && $past(rst)) begin
            a_r1_reset_clear: assert (!upd_strobe && mod_active == '0 && mod_pending == '0
                                      && n_int == '0 && n_frac == '0 && r_count == '0);
        end
    end
endmodule

bind synth_prog_regfile sp_regfile_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .n_int       (n_int),
    .n_frac      (n_frac),
    .r_count     (r_count),
    .mod_pending (mod_pending),
    .mod_active  (mod_active),
    .ctrl_word   (ctrl_word),
    .noise_word  (noise_word),
    .upd_strobe  (upd_strobe),
    .upd_idx     (upd_idx)
);

// File: tb/tb_synth_prog_regfile.sv
module tb_synth_prog_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_le = 1'b0;
    logic [8:0]  n_int;
    logic [11:0] n_frac;
    logic [3:0]  r_count;
    logic [11:0] mod_pending;
    logic [11:0] mod_active;
    logic [21:0] ctrl_word;
    logic [21:0] noise_word;
    logic        upd_strobe;
    logic [1:0]  upd_idx;

    int checks = 0;
    int failures = 0;
    int strobe_cnt = 0;
    logic [1:0] last_idx = 2'd0;
    bit done = 0;

    // expected model
    logic [8:0]  e_int = '0;
    logic [11:0] e_frac = '0;
    logic [3:0]  e_rcnt = '0;
    logic [11:0] e_pend = '0;
    logic [11:0] e_act = '0;
    logic [21:0] e_ctrl = '0;
    logic [21:0] e_noise = '0;
    int          e_strobes = 0;
    logic [1:0]  e_idx = 2'd0;

    always #2.5 clk = ~clk;

    synth_prog_regfile dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .n_int(n_int), .n_frac(n_frac), .r_count(r_count), .mod_pending(mod_pending),
        .mod_active(mod_active), .ctrl_word(ctrl_word), .noise_word(noise_word),
        .upd_strobe(upd_strobe), .upd_idx(upd_idx)
    );

    always @(negedge clk) begin
        if (!rst && upd_strobe) begin
            strobe_cnt <= strobe_cnt + 1;
            last_idx   <= upd_idx;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(2);
    endtask

    // spec model of a transfer of word w
    task automatic model(input logic [23:0] w);
        e_strobes++;
        e_idx = w[1:0];
        case (w % 4)
            0: begin
                e_frac = 12'((w >> 2) % 4096);
                e_int  = 9'((w >> 14) % 512);
                e_act  = e_pend;
            end
            1: begin
                e_pend = 12'((w >> 2) % 4096);
                e_rcnt = 4'((w >> 14) % 16);
            end
            2: e_ctrl  = 22'(w >> 2);
            default: e_noise = 22'(w >> 2);
        endcase
    endtask

    task automatic le_rise();
        ser_le = 1'b1;
        wait_clk(10);
    endtask

    task automatic le_fall();
        ser_le = 1'b0;
        wait_clk(6);
    endtask

    task automatic send(input logic [23:0] w);
        shift_bits({8'h0, w}, 24);
        le_rise();
        le_fall();
        model(w);
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk(n_int == e_int,           {tag, " R4 n_int"},  n_int, e_int);
        chk(n_frac == e_frac,         {tag, " R4 n_frac"}, n_frac, e_frac);
        chk(r_count == e_rcnt,        {tag, " R5 r_count"}, r_count, e_rcnt);
        chk(mod_pending == e_pend,    {tag, " R5 mod_pending"}, mod_pending, e_pend);
        chk(mod_active == e_act,      {tag, " R6/R7 mod_active"}, mod_active, e_act);
        chk(ctrl_word == e_ctrl,      {tag, " R8 ctrl_word"}, ctrl_word, e_ctrl);
        chk(noise_word == e_noise,    {tag, " R8 noise_word"}, noise_word, e_noise);
        chk(strobe_cnt == e_strobes,  {tag, " R9 strobe count"}, strobe_cnt, e_strobes);
        chk(last_idx == e_idx,        {tag, " R9 upd_idx"}, last_idx, e_idx);
    endtask

    initial begin : watchdog
        wait_clk(150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] w;
        wait_clk(4);
        @(negedge clk);
        // R1: outputs clear during reset
        chk(upd_strobe == 1'b0 && mod_active == '0 && n_int == '0, "R1 in reset",
            {upd_strobe, mod_active, n_int}, 0);
        rst = 1'b0;
        wait_clk(6);
        check_all("R1 after reset");

        // R5 R6: reference write goes to pending only; high bits ignored
        send(24'hFCA5_5D | 24'h1);  // bits[1:0]=01
        check_all("R5 R6 ref write");
        // R4 R7: divider write commits, bit 23 ignored
        send(24'h9ABC_D0);
        check_all("R4 R7 div commit");
        // R7: divider write without new pending keeps active
        send(24'h1234_58);
        check_all("R7 recommit same");
        // R8 R3: control and noise words
        send(24'hABCDE6);
        check_all("R3 R8 ctrl");
        send(24'h5A5A5B);
        check_all("R3 R8 noise");

        // R11: shifting without latch changes nothing
        shift_bits(32'h00C3_3C01, 24);
        check_all("R11 shift no latch");

        // R10: latch high -> shifting accepted, no transfer until next rise
        w = 24'h3C3C01;        // shreg currently holds 0xC33C01
        le_rise();
        model(24'hC33C01);     // rise transfers present contents (R10)
        shift_bits(32'h0000_0000 | w, 24);
        check_all("R10 shift while le high");
        le_fall();
        le_rise();
        le_fall();
        model(w);
        check_all("R10 rise uses current contents");

        // R2: over-length shift keeps the last 24 bits
        shift_bits(32'hDEAD_BE00 ^ 32'h00F0_0029, 32);
        le_rise();
        le_fall();
        model(24'((32'hDEAD_BE00 ^ 32'h00F0_0029) % (1 << 24)));
        check_all("R2 over-length");

        // sweep: computed patterns over all four destinations
        for (int k = 0; k < 24; k++) begin
            logic [23:0] pat;
            pat = 24'((k * 32'h0009_E3B7 + 32'h0001_2345 * (k + 1)) % (1 << 24));
            pat[1:0] = 2'(k % 4);
            send(pat);
            check_all("R2 R3 sweep");
        end
        // sweep: modulus double buffering pairs
        for (int k = 0; k < 12; k++) begin
            logic [23:0] rw;
            logic [23:0] nw;
            rw = 24'({10'(k * 37), 12'(k * 331 + 7), 2'b01});
            nw = 24'({10'(k * 53 + 1), 12'(k * 97), 2'b00});
            send(rw);
            check_all("R6 pair ref");
            send(nw);
            check_all("R7 pair div");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule